// File: doc/BRIEF.md
# SPI Master Register Interface

This block is the software-visible register file of an SPI master controller. It sits behind a single-cycle, word-addressed 32-bit read/write bus. It holds the control word and the storage-only configuration words: interrupt enable, DMA control, wait, clock control, burst count and transfer count. The TX FIFO, RX FIFO, interrupt-status logic and exchange engine are separate blocks, and this block reaches them through ports.

Software pushes bytes into the TX FIFO and pops bytes from the RX FIFO through two data windows, and it reads the fill level of both FIFOs from one status word. Control writes drive four chip-select lines. They can also request a flush of either FIFO, or the start of an exchange. Interrupt-status reads are forwarded from the status block, and status writes are forwarded to it as a write-one-to-clear mask. Until the enable bit is set, only the control word accepts writes.

Top module: `spi_regif`

Byte offsets used below: 0x00 RX data, 0x04 TX data, 0x08 control, 0x0C interrupt enable, 0x10 interrupt status, 0x14 DMA control, 0x18 wait, 0x1C clock control, 0x20 burst count, 0x24 transfer count, 0x28 FIFO status.

## Requirements
- R1: After reset, control reads 0x0002001C and clock control reads 0x00000002. Interrupt enable, DMA control, wait, burst count, transfer count and bus_rdata are all 0.
- R2: While control bit 0 (enable) is 0:
  - writes to any offset other than control change no register and raise no FIFO push or status clear;
  - reads of RX data, TX data and FIFO status return 0 and do not pop the RX FIFO.
- R3: With enable set, a write to TX data presents bits 7:0 on tx_push_data and pulses tx_push in that same cycle. When tx_full is high the byte is dropped and tx_push stays low.
- R4: With enable set, a read of RX data pulses rx_pop in the request cycle and returns the head byte zero-extended. When rx_empty is high it returns 0xDEADBEEF and does not pop. A read of TX data returns 0.
- R5: With enable set, FIFO status reads tx_count in bits 22:16 and rx_count in bits 6:0, with every other bit 0.
- R6: A control write with bit 8 set pulses tx_flush for one cycle in the cycle after the write; bit 9 does the same for rx_flush. Neither bit is stored: both read back 0.
- R7: Control bits 13:12 pick one chip-select line. That line follows control bit 17 and every other line follows control bit 4, starting in the cycle after the control write.
- R8: A control write with bit 10 set pulses xch_start in the next cycle. Bit 10 then reads 1 until the cycle after xch_done is high.
- R9: Interrupt status reads return irq_status. With enable set, a status write pulses sta_clr with sta_clr_mask equal to the write data ANDed with 0x00037F7F, so bit 31 is never cleared.
- R10: Offsets above 0x28 read as 0, and writes to them have no effect.
- R11: Read data appears on bus_rdata one cycle after the read request and holds until the next read. Writes to storage words keep only their defined bits: interrupt enable 0x00037F7F, wait 0x0000FFFF, burst and transfer count 0x00FFFFFF, control 0x000FFCFF, DMA and clock control all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_push | output | 1 | Push strobe to TX FIFO |
| tx_push_data | output | 8 | Byte to push |
| tx_full | input | 1 | TX FIFO full |
| tx_count | input | CNT_W (7) | TX FIFO fill level |
| rx_pop | output | 1 | Pop strobe to RX FIFO |
| rx_head | input | 8 | RX FIFO head byte (show-ahead) |
| rx_empty | input | 1 | RX FIFO empty |
| rx_count | input | CNT_W (7) | RX FIFO fill level |
| tx_flush | output | 1 | One-cycle TX FIFO reset |
| rx_flush | output | 1 | One-cycle RX FIFO reset |
| xch_start | output | 1 | One-cycle exchange request |
| xch_done | input | 1 | Exchange finished, clears control bit 10 |
| irq_status | input | 32 | Current interrupt status word |
| sta_clr | output | 1 | Status clear strobe |
| sta_clr_mask | output | 32 | Bits to clear |
| cs_level | output | NUM_CS (4) | Chip-select line levels |
| ctrl_o | output | 32 | Stored control word |
| int_en_o | output | 32 | Interrupt enable word |
| dma_ctl_o | output | 32 | DMA control word |
| wait_o | output | 32 | Wait word |
| clk_ctl_o | output | 32 | Clock control word |
| burst_o | output | 32 | Burst count |
| xfer_o | output | 32 | Transfer count |

## Verification
Three kinds of result are due at different times:
- Strobes toward the FIFOs and the status block (tx_push, rx_pop, sta_clr) are combinational in the request cycle. The bench samples them one time step after it drives the request, before the capturing edge.
- Stored words, chip-select levels and the flush and exchange pulses change at the edge that takes the write. The bench checks them at the falling edge that follows.
- Read data is registered at the request edge and checked at the falling edge one cycle after the request.

Every check samples away from the rising edge, so its cycle is fixed by counting those registers.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   localparam logic [3:0] IDX_RXD   = 4'd0;
   localparam logic [3:0] IDX_TXD   = 4'd1;
   localparam logic [3:0] IDX_CTRL  = 4'd2;
   localparam logic [3:0] IDX_IEN   = 4'd3;
   localparam logic [3:0] IDX_STA   = 4'd4;
   localparam logic [3:0] IDX_DMA   = 4'd5;
   localparam logic [3:0] IDX_WAIT  = 4'd6;
   localparam logic [3:0] IDX_CLK   = 4'd7;
   localparam logic [3:0] IDX_BURST = 4'd8;
   localparam logic [3:0] IDX_XFER  = 4'd9;
   localparam logic [3:0] IDX_FSTAT = 4'd10;
   localparam logic [3:0] IDX_LAST  = IDX_FSTAT;

   localparam int B_EN       = 0;
   localparam int B_IDLE_LVL = 4;
   localparam int B_TX_FLUSH = 8;
   localparam int B_RX_FLUSH = 9;
   localparam int B_XCH      = 10;
   localparam int B_SEL_LO   = 12;
   localparam int B_SEL_LVL  = 17;
   localparam int FS_TX_LO   = 16;

   localparam logic [31:0] CTRL_RST   = 32'h0002_001C;
   localparam logic [31:0] CLK_RST    = 32'h0000_0002;
   localparam logic [31:0] CTRL_KEEP  = 32'h000F_FCFF;
   localparam logic [31:0] IEN_KEEP   = 32'h0003_7F7F;
   localparam logic [31:0] STA_KEEP   = 32'h0003_7F7F;
   localparam logic [31:0] WAIT_KEEP  = 32'h0000_FFFF;
   localparam logic [31:0] COUNT_KEEP = 32'h00FF_FFFF;

   typedef struct packed {
      logic       rd;
      logic       in_range;
      logic       wr_ctrl;
      logic       wr_reg;
      logic [3:0] idx;
   } acc_t;

endpackage

// File: rtl/spi_regif_decode.sv
module spi_regif_decode
   import spi_regif_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic              enable,
   output acc_t              acc
);
   localparam int WORD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 7) begin : g_bad_addr_w
         $error("spi_regif_decode: ADDR_W must be at least 7");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic              hit;

   always_comb begin
      word    = addr[ADDR_W-1:2];
      aligned = (addr[1:0] == 2'b00);
      hit     = aligned && (word[WORD_W-1:4] == '0) && (word[3:0] <= IDX_LAST);
      acc.idx      = word[3:0];
      acc.in_range = hit;
      acc.rd       = valid && !write;
      acc.wr_ctrl  = valid && write && hit && (word[3:0] == IDX_CTRL);
      acc.wr_reg   = valid && write && hit && enable && (word[3:0] != IDX_CTRL);
   end

endmodule

// File: rtl/spi_regif_cs.sv
module spi_regif_cs
   import spi_regif_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input  logic [31:0]       ctrl,
   output logic [NUM_CS-1:0] cs_level
);
   localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   generate
      if (NUM_CS != 2 && NUM_CS != 4) begin : g_bad_cs
         $error("spi_regif_cs: NUM_CS must be 2 or 4");
      end
   endgenerate

   logic [SEL_W-1:0] sel;
   assign sel = ctrl[B_SEL_LO +: SEL_W];

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_line
         assign cs_level[i] = (sel == SEL_W'(i)) ? ctrl[B_SEL_LVL] : ctrl[B_IDLE_LVL];
      end
   endgenerate

endmodule

// File: rtl/spi_regif_rdmux.sv
module spi_regif_rdmux
   import spi_regif_pkg::*;
#(
   parameter int          CNT_W  = 7,
   parameter logic [31:0] POISON = 32'hDEAD_BEEF
) (
   input  acc_t             acc,
   input  logic             enable,
   input  logic [31:0]      ctrl,
   input  logic [31:0]      int_en,
   input  logic [31:0]      irq_status,
   input  logic [31:0]      dma_ctl,
   input  logic [31:0]      wait_w,
   input  logic [31:0]      clk_ctl,
   input  logic [31:0]      burst,
   input  logic [31:0]      xfer,
   input  logic [7:0]       rx_head,
   input  logic             rx_empty,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output logic [31:0]      rd_value
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("spi_regif_rdmux: CNT_W must be 1..16");
      end
   endgenerate

   logic [31:0] fifo_word;

   always_comb begin
      fifo_word = '0;
      fifo_word[FS_TX_LO +: CNT_W] = tx_count;
      fifo_word[0 +: CNT_W]        = rx_count;
   end

   always_comb begin
      rd_value = '0;
      if (acc.in_range) begin
         unique case (acc.idx)
            IDX_RXD:   if (enable) rd_value = rx_empty ? POISON : {24'd0, rx_head};
            IDX_CTRL:  rd_value = ctrl;
            IDX_IEN:   rd_value = int_en;
            IDX_STA:   rd_value = irq_status;
            IDX_DMA:   rd_value = dma_ctl;
            IDX_WAIT:  rd_value = wait_w;
            IDX_CLK:   rd_value = clk_ctl;
            IDX_BURST: rd_value = burst;
            IDX_XFER:  rd_value = xfer;
            IDX_FSTAT: if (enable) rd_value = fifo_word;
            default:   rd_value = '0;
         endcase
      end
   end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
   import spi_regif_pkg::*;
#(
   parameter int          ADDR_W = 8,
   parameter int          CNT_W  = 7,
   parameter int          NUM_CS = 4,
   parameter logic [31:0] POISON = 32'hDEAD_BEEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              tx_push,
   output logic [7:0]        tx_push_data,
   input  logic              tx_full,
   input  logic [CNT_W-1:0]  tx_count,
   output logic              rx_pop,
   input  logic [7:0]        rx_head,
   input  logic              rx_empty,
   input  logic [CNT_W-1:0]  rx_count,
   output logic              tx_flush,
   output logic              rx_flush,
   output logic              xch_start,
   input  logic              xch_done,
   input  logic [31:0]       irq_status,
   output logic              sta_clr,
   output logic [31:0]       sta_clr_mask,
   output logic [NUM_CS-1:0] cs_level,
   output logic [31:0]       ctrl_o,
   output logic [31:0]       int_en_o,
   output logic [31:0]       dma_ctl_o,
   output logic [31:0]       wait_o,
   output logic [31:0]       clk_ctl_o,
   output logic [31:0]       burst_o,
   output logic [31:0]       xfer_o
);
   localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4 * IDX_CTRL);

   acc_t        acc;
   logic        enable;
   logic [31:0] ctrl_q, int_en_q, dma_q, wait_q, clk_q, burst_q, xfer_q;
   logic [31:0] rd_value;
   logic [31:0] rdata_q;
   logic        tx_flush_q, rx_flush_q, xch_q;

   assign enable = ctrl_q[B_EN];

   spi_regif_decode #(.ADDR_W(ADDR_W)) u_decode (
      .valid  (bus_valid),
      .write  (bus_write),
      .addr   (bus_addr),
      .enable (enable),
      .acc    (acc)
   );

   spi_regif_cs #(.NUM_CS(NUM_CS)) u_cs (
      .ctrl     (ctrl_q),
      .cs_level (cs_level)
   );

   spi_regif_rdmux #(.CNT_W(CNT_W), .POISON(POISON)) u_rdmux (
      .acc        (acc),
      .enable     (enable),
      .ctrl       (ctrl_q),
      .int_en     (int_en_q),
      .irq_status (irq_status),
      .dma_ctl    (dma_q),
      .wait_w     (wait_q),
      .clk_ctl    (clk_q),
      .burst      (burst_q),
      .xfer       (xfer_q),
      .rx_head    (rx_head),
      .rx_empty   (rx_empty),
      .tx_count   (tx_count),
      .rx_count   (rx_count),
      .rd_value   (rd_value)
   );

   // FIFO and status strobes, combinational in the request cycle
   assign tx_push      = acc.wr_reg && (acc.idx == IDX_TXD) && !tx_full;
   assign tx_push_data = bus_wdata[7:0];
   assign rx_pop       = acc.rd && acc.in_range && (acc.idx == IDX_RXD) && enable && !rx_empty;
   assign sta_clr      = acc.wr_reg && (acc.idx == IDX_STA);
   assign sta_clr_mask = bus_wdata & STA_KEEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         int_en_q <= '0;
         dma_q    <= '0;
         wait_q   <= '0;
         clk_q    <= CLK_RST;
         burst_q  <= '0;
         xfer_q   <= '0;
      end else begin
         if (acc.wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_KEEP;
         end else if (xch_done) begin
            ctrl_q[B_XCH] <= 1'b0;
         end
         if (acc.wr_reg) begin
            unique case (acc.idx)
               IDX_IEN:   int_en_q <= bus_wdata & IEN_KEEP;
               IDX_DMA:   dma_q    <= bus_wdata;
               IDX_WAIT:  wait_q   <= bus_wdata & WAIT_KEEP;
               IDX_CLK:   clk_q    <= bus_wdata;
               IDX_BURST: burst_q  <= bus_wdata & COUNT_KEEP;
               IDX_XFER:  xfer_q   <= bus_wdata & COUNT_KEEP;
               default:   ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_flush_q <= 1'b0;
         rx_flush_q <= 1'b0;
         xch_q      <= 1'b0;
         rdata_q    <= '0;
      end else begin
         tx_flush_q <= acc.wr_ctrl && bus_wdata[B_TX_FLUSH];
         rx_flush_q <= acc.wr_ctrl && bus_wdata[B_RX_FLUSH];
         xch_q      <= acc.wr_ctrl && bus_wdata[B_XCH];
         if (acc.rd) rdata_q <= rd_value;
      end
   end

   assign tx_flush  = tx_flush_q;
   assign rx_flush  = rx_flush_q;
   assign xch_start = xch_q;
   assign bus_rdata = rdata_q;
   assign ctrl_o    = ctrl_q;
   assign int_en_o  = int_en_q;
   assign dma_ctl_o = dma_q;
   assign wait_o    = wait_q;
   assign clk_ctl_o = clk_q;
   assign burst_o   = burst_q;
   assign xfer_o    = xfer_q;

   // R2: nothing reaches the FIFOs or status block while disabled
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!tx_push && !rx_pop && !sta_clr));

   // R3: never push into a full TX FIFO
   p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> !tx_full);

   // R4: never pop an empty RX FIFO
   p_pop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> !rx_empty);

   // R6: a flush pulse follows a control write that asked for it
   p_flush_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |-> $past(bus_valid && bus_write && bus_addr == CTRL_ADDR && bus_wdata[B_TX_FLUSH]));

   // R6: the flush request bits are never stored
   p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o[B_TX_FLUSH] && !ctrl_o[B_RX_FLUSH]);

   // R7: the selected line takes the written level one cycle later
   p_cs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == CTRL_ADDR) |=>
         (cs_level[$past(bus_wdata[B_SEL_LO +: SEL_W])] == $past(bus_wdata[B_SEL_LVL])));

   // R8: an exchange request follows a control write with the start bit
   p_xch_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xch_start |-> $past(bus_valid && bus_write && bus_addr == CTRL_ADDR && bus_wdata[B_XCH]));

   // R9: the status clear mask never carries bit 31
   p_clr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sta_clr |-> !sta_clr_mask[31]);

endmodule

// File: tb/tb_spi_regif.sv
module tb_spi_regif;

   localparam logic [7:0] A_RXD = 8'h00, A_TXD = 8'h04, A_CTRL = 8'h08, A_IEN = 8'h0C,
                          A_STA = 8'h10, A_DMA = 8'h14, A_WAIT = 8'h18, A_CLK = 8'h1C,
                          A_BURST = 8'h20, A_XFER = 8'h24, A_FSTAT = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_push, tx_full = 1'b0;
   logic [7:0]  tx_push_data;
   logic [6:0]  tx_count = '0, rx_count = '0;
   logic        rx_pop, rx_empty = 1'b1;
   logic [7:0]  rx_head = '0;
   logic        tx_flush, rx_flush, xch_start, xch_done = 1'b0;
   logic [31:0] irq_status = 32'h0000_1B00;
   logic        sta_clr;
   logic [31:0] sta_clr_mask;
   logic [3:0]  cs_level;
   logic [31:0] ctrl_o, int_en_o, dma_ctl_o, wait_o, clk_ctl_o, burst_o, xfer_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic        cap_push, cap_pop, cap_clr;
   logic [7:0]  cap_pdata;
   logic [31:0] cap_mask, rd;

   always #4 clk = ~clk;

   spi_regif dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_full(tx_full), .tx_count(tx_count),
      .rx_pop(rx_pop), .rx_head(rx_head), .rx_empty(rx_empty), .rx_count(rx_count),
      .tx_flush(tx_flush), .rx_flush(rx_flush), .xch_start(xch_start), .xch_done(xch_done),
      .irq_status(irq_status), .sta_clr(sta_clr), .sta_clr_mask(sta_clr_mask),
      .cs_level(cs_level), .ctrl_o(ctrl_o), .int_en_o(int_en_o), .dma_ctl_o(dma_ctl_o),
      .wait_o(wait_o), .clk_ctl_o(clk_ctl_o), .burst_o(burst_o), .xfer_o(xfer_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      cap_push = tx_push; cap_pdata = tx_push_data; cap_clr = sta_clr; cap_mask = sta_clr_mask;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      cap_pop = rx_pop;
      @(negedge clk);
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ctrl_o", ctrl_o, 32'h0002_001C);
      chk("R1 clk_ctl_o", clk_ctl_o, 32'h2);
      chk("R1 others", int_en_o | dma_ctl_o | wait_o | burst_o | xfer_o, 32'h0);
      chk("R1 rdata", bus_rdata, 32'h0);
      chk("R7 reset cs", {28'd0, cs_level}, 32'hF);
      do_read(A_CTRL, rd);
      chk("R11 ctrl read one cycle later", rd, 32'h0002_001C);
   endtask

   task automatic t_disabled();
      do_write(A_IEN, 32'hFF);
      chk("R2 ien ignored", int_en_o, 32'h0);
      do_write(A_TXD, 32'h55);
      chk("R2 no push", {31'd0, cap_push}, 32'h0);
      do_write(A_STA, 32'hFFFF_FFFF);
      chk("R2 no status clear", {31'd0, cap_clr}, 32'h0);
      rx_empty = 1'b0; rx_head = 8'h77; tx_count = 7'd3;
      do_read(A_RXD, rd);
      chk("R2 no pop", {31'd0, cap_pop}, 32'h0);
      chk("R2 rx read 0", rd, 32'h0);
      do_read(A_FSTAT, rd);
      chk("R2 fifo status 0", rd, 32'h0);
      rx_empty = 1'b1; tx_count = '0;
   endtask

   task automatic t_cs();
      do_write(A_CTRL, 32'h0000_0001);
      chk("R7 all low", {28'd0, cs_level}, 32'h0);
      do_write(A_CTRL, 32'h0000_2011);
      chk("R7 sel2 low idle high", {28'd0, cs_level}, 32'hB);
      do_write(A_CTRL, 32'h0002_3001);
      chk("R7 sel3 high idle low", {28'd0, cs_level}, 32'h8);
      do_write(A_CTRL, 32'h0000_0001);
   endtask

   task automatic t_tx();
      tx_full = 1'b0;
      do_write(A_TXD, 32'h0000_01A5);
      chk("R3 push", {31'd0, cap_push}, 32'h1);
      chk("R3 push byte", {24'd0, cap_pdata}, 32'hA5);
      tx_full = 1'b1;
      do_write(A_TXD, 32'h0000_0033);
      chk("R3 full drops", {31'd0, cap_push}, 32'h0);
      tx_full = 1'b0;
   endtask

   task automatic t_storage();
      do_write(A_IEN, 32'hFFFF_FFFF);
      chk("R11 ien mask", int_en_o, 32'h0003_7F7F);
      do_write(A_WAIT, 32'hFFFF_FFFF);
      chk("R11 wait mask", wait_o, 32'h0000_FFFF);
      do_write(A_BURST, 32'hFFFF_FFFF);
      chk("R11 burst mask", burst_o, 32'h00FF_FFFF);
      do_write(A_XFER, 32'h1234_5678);
      chk("R11 xfer mask", xfer_o, 32'h0034_5678);
      do_write(A_DMA, 32'hCAFE_F00D);
      chk("R11 dma", dma_ctl_o, 32'hCAFE_F00D);
      do_write(A_CLK, 32'h8765_4321);
      do_read(A_CLK, rd);
      chk("R11 clk read", rd, 32'h8765_4321);
   endtask

   task automatic t_rx();
      rx_empty = 1'b0; rx_head = 8'h3C;
      do_read(A_RXD, rd);
      chk("R4 pop", {31'd0, cap_pop}, 32'h1);
      chk("R4 data", rd, 32'h3C);
      rx_empty = 1'b1;
      do_read(A_RXD, rd);
      chk("R4 empty no pop", {31'd0, cap_pop}, 32'h0);
      chk("R4 poison", rd, 32'hDEAD_BEEF);
      do_read(A_TXD, rd);
      chk("R4 tx read 0", rd, 32'h0);
   endtask

   task automatic t_fstat();
      tx_count = 7'd5; rx_count = 7'h40;
      do_read(A_FSTAT, rd);
      chk("R5 counts", rd, 32'h0005_0040);
      tx_count = 7'h7F; rx_count = 7'h01;
      do_read(A_FSTAT, rd);
      chk("R5 full counts", rd, 32'h007F_0001);
   endtask

   task automatic t_status();
      irq_status = 32'h8000_1B04;
      do_read(A_STA, rd);
      chk("R9 status read", rd, 32'h8000_1B04);
      do_write(A_STA, 32'hFFFF_FFFF);
      chk("R9 clear strobe", {31'd0, cap_clr}, 32'h1);
      chk("R9 clear mask", cap_mask, 32'h0003_7F7F);
   endtask

   task automatic t_flush();
      do_write(A_CTRL, 32'h0000_0101);
      chk("R6 tx flush", {30'd0, tx_flush, rx_flush}, 32'h2);
      @(negedge clk);
      chk("R6 tx flush one cycle", {31'd0, tx_flush}, 32'h0);
      do_read(A_CTRL, rd);
      chk("R6 bit clears", rd, 32'h1);
      do_write(A_CTRL, 32'h0000_0201);
      chk("R6 rx flush", {30'd0, tx_flush, rx_flush}, 32'h1);
   endtask

   task automatic t_xch();
      do_write(A_CTRL, 32'h0000_0401);
      chk("R8 start pulse", {31'd0, xch_start}, 32'h1);
      do_read(A_CTRL, rd);
      chk("R8 bit held", rd, 32'h401);
      chk("R8 pulse ended", {31'd0, xch_start}, 32'h0);
      @(negedge clk); xch_done = 1'b1;
      @(negedge clk); xch_done = 1'b0;
      do_read(A_CTRL, rd);
      chk("R8 done clears", rd, 32'h1);
   endtask

   task automatic t_range();
      do_write(8'h2C, 32'hFFFF_FFFF);
      chk("R10 write no effect", ctrl_o, 32'h1);
      do_read(8'h2C, rd);
      chk("R10 read 0x2C", rd, 32'h0);
      do_read(8'h3C, rd);
      chk("R10 read 0x3C", rd, 32'h0);
      do_write(A_CTRL, 32'h0);
      do_write(A_BURST, 32'h77);
      chk("R2 burst ignored after disable", burst_o, 32'h00FF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_cs();
      t_tx();
      t_storage();
      t_rx();
      t_fstat();
      t_status();
      t_flush();
      t_xch();
      t_range();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule